// File: doc/BRIEF.md
# Codec Control Command Register File

This block sits on the codec side of a two-wire-per-direction audio link, after the serial deframer. For each incoming frame the deframer hands it the parsed command slot word, the command data slot word, and the valid tags of both slots, together with a one-cycle `frame_go` strobe. The block decodes the command word and applies it to a bank of sixty-four 16-bit control registers. All register contents are driven out in parallel for the mixer and power logic that decode them.

A write updates one register. A read is answered in the next frame: the echoed register index goes into the status address slot word, the register value goes into the status data slot word, and both status tags are raised for exactly one frame. Only even indices map to storage. Register k lives at index 2k. An odd write is dropped, and an odd read answers 0000h.

A small state machine tracks read responses. Its states are IDLE (nothing pending, nothing shown), PEND (a read was captured and nothing is shown), SHOW (a response is shown and nothing is pending) and SHOW_PEND (a response is shown and another read is pending). Every transition happens on `frame_go`. IDLE goes to PEND on a read and otherwise stays in IDLE. PEND loads the response, then goes to SHOW_PEND on a new read or to SHOW otherwise. SHOW clears the response, then goes to PEND on a new read or to IDLE otherwise. SHOW_PEND loads the response, then stays in SHOW_PEND on a new read or goes to SHOW otherwise.

Top module: `codec_cmd_regfile`

## Requirements
- R1: A synchronous reset clears every control register to 0000h. It also clears both status words and both status tags.
- R2: A write is decoded from a `frame_go` cycle with both slot tags set, slot 1 bit 19 at 0 and an even index in slot 1 bits 18:12. In that case register index/2 takes slot 2 bits 19:4 at that clock edge.
- R3: A write frame with the slot 1 tag or the slot 2 tag clear changes no register.
- R4: A write to an odd index changes no register.
- R5: A read is decoded from a `frame_go` cycle with the slot 1 tag set and slot 1 bit 19 at 1; the slot 2 tag plays no part in a read. At the edge of the next frame, the status address word becomes {0, index, 12'h000} and the status data word becomes {value, 4'h0}, and both tags go to 1. If that frame brings no further read, tags and words return to 0 at the frame after.
- R6: A read of an odd index echoes that index and returns data 0000h.
- R7: Slot 1 bits 11:0 and slot 2 bits 3:0 have no effect on any register or status output.
- R8: Reads in consecutive frames are each answered in the frame that follows their own, with no gap between responses.
- R9: When the frame that carries a response also carries a write to the register being read, the response shows the value from before that write.
- R10: Registers and status outputs change only at a `frame_go` edge or in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_go | input | 1 | One-cycle strobe: slot words and tags of a frame are valid |
| slot1_tag | input | 1 | Command address slot valid tag |
| slot2_tag | input | 1 | Command data slot valid tag |
| slot1_word | input | 20 | Command address slot word |
| slot2_word | input | 20 | Command data slot word |
| ctrl_regs | output | 1024 | All registers, register k at bits 16k+15:16k |
| stat_addr_word | output | 20 | Status address slot word |
| stat_data_word | output | 20 | Status data slot word |
| stat_addr_tag | output | 1 | Status address slot valid tag |
| stat_data_tag | output | 1 | Status data slot valid tag |

## Verification
Two functions can fall in the same cycle. The response to a pending read is loaded on the edge where the next frame's command is also taken, and that command may be a write to the same register or another read. The bench reads a register and then, in the very next frame, writes a new value to it. It then expects the status data to show the old value while the register output shows the new one. It also sweeps all 128 indices with back-to-back reads, so every response edge also captures the next request, and it checks each answer against a model built from the earlier write sweep.

// File: rtl/cmdrf_pkg.sv
package cmdrf_pkg;

    // response tracking states; transitions happen only on frame_go
    typedef enum logic [1:0] {
        RSP_IDLE      = 2'd0,
        RSP_PEND      = 2'd1,
        RSP_SHOW      = 2'd2,
        RSP_SHOW_PEND = 2'd3
    } rsp_state_e;

    localparam int DEF_SLOT_W = 20;
    localparam int DEF_IDX_W  = 7;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_NREGS  = 64;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode #(
    parameter int SLOT_W   = 20,
    parameter int IDX_W    = 7,
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 64,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic              frame_go,
    input  logic              slot1_tag,
    input  logic              slot2_tag,
    input  logic [SLOT_W-1:0] slot1_word,
    input  logic [SLOT_W-1:0] slot2_word,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_sel,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_req,
    output logic [IDX_W-1:0]  rd_idx
);
    localparam int OP_POS  = SLOT_W - 1;
    localparam int IDX_TOP = SLOT_W - 2;
    localparam int RSV1_W  = SLOT_W - 1 - IDX_W;
    localparam int RSV2_W  = SLOT_W - DATA_W;

    logic [IDX_W-1:0]  cmd_idx;
    logic [IDX_W-2:0]  half_idx;
    logic              is_read;
    logic              idx_even;
    logic              idx_in_range;
    logic              unused_rsv;

    assign cmd_idx  = slot1_word[IDX_TOP -: IDX_W];
    assign half_idx = cmd_idx[IDX_W-1:1];
    assign is_read  = slot1_word[OP_POS];
    assign idx_even = ~cmd_idx[0];

    // reserved fields take no part in decoding
    assign unused_rsv = &{slot1_word[RSV1_W-1:0], slot2_word[RSV2_W-1:0], half_idx};

    generate
        if (NUM_REGS >= (1 << (IDX_W - 1))) begin : g_full_map
            assign idx_in_range = 1'b1;
        end else begin : g_part_map
            assign idx_in_range = (int'(half_idx) < NUM_REGS);
        end
    endgenerate

    always_comb begin
        wr_en   = frame_go && slot1_tag && slot2_tag && !is_read
                  && idx_even && idx_in_range;
        wr_sel  = half_idx[SEL_W-1:0];
        wr_data = slot2_word[SLOT_W-1 -: DATA_W];
        rd_req  = frame_go && slot1_tag && is_read;
        rd_idx  = cmd_idx;
    end

endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
    parameter int NUM_REGS = 64,
    parameter int DATA_W   = 16,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_ok,
    input  logic [SEL_W-1:0]           rd_sel,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] cells [NUM_REGS];

    generate
        for (genvar k = 0; k < NUM_REGS; k++) begin : g_cell
            always_ff @(posedge clk) begin
                if (rst) begin
                    cells[k] <= '0;
                end else if (wr_en && (wr_sel == SEL_W'(k))) begin
                    cells[k] <= wr_data;
                end
            end
            assign regs_flat[k*DATA_W +: DATA_W] = cells[k];
        end
    endgenerate

    assign rd_data = rd_ok ? cells[rd_sel] : '0;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cells[$past(wr_sel)] == $past(wr_data))); // R2

endmodule

// File: rtl/resp_fsm.sv
module resp_fsm
    import cmdrf_pkg::*;
#(
    parameter int SLOT_W   = 20,
    parameter int IDX_W    = 7,
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 64,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_go,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_ok,
    output logic [SEL_W-1:0]  rd_sel,
    output logic [SLOT_W-1:0] stat_addr_word,
    output logic [SLOT_W-1:0] stat_data_word,
    output logic              stat_addr_tag,
    output logic              stat_data_tag
);
    localparam int ADDR_PAD = SLOT_W - 1 - IDX_W;
    localparam int DATA_PAD = SLOT_W - DATA_W;

    rsp_state_e       state_q, state_d;
    logic [IDX_W-1:0] pend_idx;
    logic [IDX_W-2:0] pend_half;
    logic             pend_in_range;
    logic             load_rsp;
    logic             clear_rsp;

    assign pend_half = pend_idx[IDX_W-1:1];
    assign rd_sel    = pend_half[SEL_W-1:0];

    generate
        if (NUM_REGS >= (1 << (IDX_W - 1))) begin : g_full_map
            assign pend_in_range = 1'b1;
        end else begin : g_part_map
            assign pend_in_range = (int'(pend_half) < NUM_REGS);
        end
    endgenerate

    assign rd_ok = ~pend_idx[0] && pend_in_range;

    // next state
    always_comb begin
        state_d   = state_q;
        load_rsp  = 1'b0;
        clear_rsp = 1'b0;
        if (frame_go) begin
            unique case (state_q)
                RSP_IDLE: begin
                    state_d = rd_req ? RSP_PEND : RSP_IDLE;
                end
                RSP_PEND: begin
                    load_rsp = 1'b1;
                    state_d  = rd_req ? RSP_SHOW_PEND : RSP_SHOW;
                end
                RSP_SHOW: begin
                    clear_rsp = 1'b1;
                    state_d   = rd_req ? RSP_PEND : RSP_IDLE;
                end
                RSP_SHOW_PEND: begin
                    load_rsp = 1'b1;
                    state_d  = rd_req ? RSP_SHOW_PEND : RSP_SHOW;
                end
                default: state_d = RSP_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= RSP_IDLE;
        else     state_q <= state_d;
    end

    // outputs and pending index
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_idx       <= '0;
            stat_addr_word <= '0;
            stat_data_word <= '0;
            stat_addr_tag  <= 1'b0;
            stat_data_tag  <= 1'b0;
        end else begin
            if (load_rsp) begin
                stat_addr_word <= {1'b0, pend_idx, {ADDR_PAD{1'b0}}};
                stat_data_word <= {rd_data, {DATA_PAD{1'b0}}};
                stat_addr_tag  <= 1'b1;
                stat_data_tag  <= 1'b1;
            end else if (clear_rsp) begin
                stat_addr_word <= '0;
                stat_data_word <= '0;
                stat_addr_tag  <= 1'b0;
                stat_data_tag  <= 1'b0;
            end
            if (frame_go && rd_req) begin
                pend_idx <= rd_idx;
            end
        end
    end

    AST_TAGS_PAIRED: assert property (@(posedge clk) disable iff (rst)
        stat_addr_tag == stat_data_tag); // R5

    AST_READ_QUEUED: assert property (@(posedge clk) disable iff (rst)
        (frame_go && rd_req) |=> (state_q == RSP_PEND || state_q == RSP_SHOW_PEND)); // R8

    AST_ODD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (stat_data_tag && stat_addr_word[ADDR_PAD]) |-> (stat_data_word == '0)); // R6

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !frame_go |=> $stable({stat_addr_word, stat_data_word, stat_addr_tag, stat_data_tag})); // R10

endmodule

// File: rtl/codec_cmd_regfile.sv
module codec_cmd_regfile
    import cmdrf_pkg::*;
#(
    parameter int SLOT_W   = DEF_SLOT_W,
    parameter int IDX_W    = DEF_IDX_W,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int NUM_REGS = DEF_NREGS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       frame_go,
    input  logic                       slot1_tag,
    input  logic                       slot2_tag,
    input  logic [SLOT_W-1:0]          slot1_word,
    input  logic [SLOT_W-1:0]          slot2_word,
    output logic [NUM_REGS*DATA_W-1:0] ctrl_regs,
    output logic [SLOT_W-1:0]          stat_addr_word,
    output logic [SLOT_W-1:0]          stat_data_word,
    output logic                       stat_addr_tag,
    output logic                       stat_data_tag
);
    localparam int SEL_W  = $clog2(NUM_REGS);
    localparam int OP_POS = SLOT_W - 1;
    localparam int IDX_LO = SLOT_W - 1 - IDX_W;

    logic              wr_en;
    logic [SEL_W-1:0]  wr_sel;
    logic [DATA_W-1:0] wr_data;
    logic              rd_req;
    logic [IDX_W-1:0]  rd_idx;
    logic              rd_ok;
    logic [SEL_W-1:0]  rd_sel;
    logic [DATA_W-1:0] rd_data;

    cmd_decode #(
        .SLOT_W(SLOT_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
    ) u_decode (
        .frame_go  (frame_go),
        .slot1_tag (slot1_tag),
        .slot2_tag (slot2_tag),
        .slot1_word(slot1_word),
        .slot2_word(slot2_word),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_req    (rd_req),
        .rd_idx    (rd_idx)
    );

    reg_bank #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_ok    (rd_ok),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .regs_flat(ctrl_regs)
    );

    resp_fsm #(
        .SLOT_W(SLOT_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
    ) u_resp (
        .clk           (clk),
        .rst           (rst),
        .frame_go      (frame_go),
        .rd_req        (rd_req),
        .rd_idx        (rd_idx),
        .rd_data       (rd_data),
        .rd_ok         (rd_ok),
        .rd_sel        (rd_sel),
        .stat_addr_word(stat_addr_word),
        .stat_data_word(stat_data_word),
        .stat_addr_tag (stat_addr_tag),
        .stat_data_tag (stat_data_tag)
    );

    AST_ODD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (frame_go && slot1_tag && !slot1_word[OP_POS] && slot1_word[IDX_LO])
        |=> $stable(ctrl_regs)); // R4

    AST_MISSING_TAG: assert property (@(posedge clk) disable iff (rst)
        (frame_go && !(slot1_tag && slot2_tag)) |=> $stable(ctrl_regs)); // R3

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !frame_go |=> $stable(ctrl_regs)); // R10

endmodule

// File: tb/tb_codec_cmd_regfile.sv
module tb_codec_cmd_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int NREGS = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_go = 1'b0;
    logic slot1_tag = 1'b0;
    logic slot2_tag = 1'b0;
    logic [19:0] slot1_word = '0;
    logic [19:0] slot2_word = '0;
    logic [NREGS*16-1:0] ctrl_regs;
    logic [19:0] stat_addr_word, stat_data_word;
    logic stat_addr_tag, stat_data_tag;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] mdl [NREGS];

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_cmd_regfile dut (
        .clk(clk), .rst(rst), .frame_go(frame_go),
        .slot1_tag(slot1_tag), .slot2_tag(slot2_tag),
        .slot1_word(slot1_word), .slot2_word(slot2_word),
        .ctrl_regs(ctrl_regs),
        .stat_addr_word(stat_addr_word), .stat_data_word(stat_data_word),
        .stat_addr_tag(stat_addr_tag), .stat_data_tag(stat_data_tag)
    );

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        int bad;
        bad = -1;
        for (int k = NREGS - 1; k >= 0; k--)
            if (ctrl_regs[k*16 +: 16] !== mdl[k]) bad = k;
        n_checks++;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s register %0d: actual=%h expected=%h",
                     req, bad, ctrl_regs[bad*16 +: 16], mdl[bad]);
        end
    endtask

    task automatic chk_resp(input string req, input int idx);
        logic [19:0] ea, ed;
        ea = {1'b0, 7'(idx), 12'h000};
        ed = (idx % 2 == 0) ? {mdl[idx/2], 4'h0} : 20'h0;
        chk(stat_addr_tag === 1'b1 && stat_data_tag === 1'b1, req, "status tags",
            {30'd0, stat_addr_tag, stat_data_tag}, 32'd3);
        chk(stat_addr_word === ea, req, "status address", {12'd0, stat_addr_word}, {12'd0, ea});
        chk(stat_data_word === ed, req, "status data", {12'd0, stat_data_word}, {12'd0, ed});
    endtask

    task automatic chk_idle(input string req);
        chk(stat_addr_tag === 1'b0 && stat_data_tag === 1'b0 &&
            stat_addr_word === '0 && stat_data_word === '0, req, "status cleared",
            {10'd0, stat_addr_tag, stat_data_tag, stat_addr_word}, 32'd0);
    endtask

    // one frame: inputs set at a falling edge, taken at the next rising edge,
    // returns at the falling edge one idle cycle later
    task automatic frame(input logic t1, input logic t2, input logic [19:0] w1,
                         input logic [19:0] w2);
        @(negedge clk);
        frame_go = 1'b1; slot1_tag = t1; slot2_tag = t2;
        slot1_word = w1; slot2_word = w2;
        @(negedge clk);
        frame_go = 1'b0; slot1_tag = 1'b0; slot2_tag = 1'b0;
        slot1_word = '0; slot2_word = '0;
        @(negedge clk);
    endtask

    function automatic logic [15:0] val_of(input int i);
        return 16'(i * 16'h0203) ^ 16'h5A3C;
    endfunction

    initial begin
        for (int k = 0; k < NREGS; k++) mdl[k] = '0;
        repeat (3) @(negedge clk);
        // reset driven while inputs are noisy
        frame_go = 1'b1; slot1_tag = 1'b1; slot2_tag = 1'b1;
        slot1_word = 20'h02000; slot2_word = 20'hFFFF0;
        @(negedge clk);
        frame_go = 1'b0; slot1_tag = 1'b0; slot2_tag = 1'b0;
        slot1_word = '0; slot2_word = '0;
        rst = 1'b0;
        @(negedge clk);
        chk_regs("R1");
        chk_idle("R1");

        // write sweep over all indices, reserved bits non-zero (R2, R4, R7)
        for (int i = 0; i < 128; i++) begin
            frame(1'b1, 1'b1, {1'b0, 7'(i), 12'((i * 37) | 1)},
                  {val_of(i), 4'(i | 8)});
            if (i % 2 == 0) begin
                mdl[i/2] = val_of(i);
                chk_regs("R2");
            end else begin
                chk_regs("R4");
            end
            if (i == 127) chk_regs("R7");
        end

        // missing tags (R3)
        frame(1'b1, 1'b0, {1'b0, 7'd4, 12'h0}, {16'hDEAD, 4'h0});
        chk_regs("R3");
        frame(1'b0, 1'b1, {1'b0, 7'd4, 12'h0}, {16'hBEEF, 4'h0});
        chk_regs("R3");
        frame(1'b0, 1'b0, {1'b0, 7'd6, 12'h0}, {16'h1234, 4'h0});
        chk_regs("R3");

        // inputs without the frame strobe (R10)
        @(negedge clk);
        slot1_tag = 1'b1; slot2_tag = 1'b1;
        slot1_word = {1'b0, 7'd8, 12'h0}; slot2_word = {16'h7777, 4'h0};
        repeat (3) @(negedge clk);
        slot1_word = {1'b1, 7'd8, 12'h0};
        repeat (3) @(negedge clk);
        slot1_tag = 1'b0; slot2_tag = 1'b0; slot1_word = '0; slot2_word = '0;
        chk_regs("R10");
        chk_idle("R10");

        // single read, then idle frames (R5)
        frame(1'b1, 1'b0, {1'b1, 7'd10, 12'h0}, 20'h0);
        chk_idle("R5");
        frame(1'b0, 1'b0, 20'h0, 20'h0);
        chk_resp("R5", 10);
        repeat (4) @(negedge clk);
        chk_resp("R5", 10);
        frame(1'b0, 1'b0, 20'h0, 20'h0);
        chk_idle("R5");

        // back-to-back read sweep, odd indices included (R6, R8)
        for (int i = 0; i < 128; i++) begin
            frame(1'b1, 1'(i % 2 == 0), {1'b1, 7'(i), 12'((i * 11) | 4)}, {16'hFFFF, 4'hF});
            if (i > 0) chk_resp(((i - 1) % 2 == 1) ? "R6" : "R8", i - 1);
        end
        frame(1'b0, 1'b0, 20'h0, 20'h0);
        chk_resp("R6", 127);
        frame(1'b0, 1'b0, 20'h0, 20'h0);
        chk_idle("R5");
        chk_regs("R5");

        // response frame also writes the register being read (R9)
        frame(1'b1, 1'b1, {1'b1, 7'd20, 12'h0}, 20'h0);
        frame(1'b1, 1'b1, {1'b0, 7'd20, 12'h0}, {16'hC0DE, 4'h0});
        chk(stat_data_word === {val_of(20), 4'h0}, "R9", "old value in response",
            {12'd0, stat_data_word}, {12'd0, val_of(20), 4'h0});
        mdl[10] = 16'hC0DE;
        chk_regs("R9");
        frame(1'b0, 1'b0, 20'h0, 20'h0);
        chk_idle("R9");

        // reset after activity (R1)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NREGS; k++) mdl[k] = '0;
        chk_regs("R1");
        chk_idle("R1");

        summary();
        $finish;
    end
endmodule